// File: doc/BRIEF.md
# Safe PLL Reconfiguration Sequencer

This block moves a clock generator's configuration word from the factor set it holds now to a newly requested one. The order of the writes keeps the generated clock from going past the faster of the two endpoints at any moment. The generator has four factors: an input pre-divider P, two feedback multipliers N and K, and an output post-divider M. A divider takes effect as soon as it is written. A multiplier change settles gradually and is reported complete by a lock status bit. For this reason the sequencer raises dividers before it touches the multipliers, and it lowers dividers only after lock is back.

A request is a single-cycle `start` pulse that carries the target N, K, M and P. When the pulse is taken, the sequencer also captures the live configuration word. It then drives write strobes with the full word, one field group per strobe. A bus-clock divider that follows the generator is raised before the change when the new setting crosses into the fast range. It is lowered after the change when the new setting crosses into the slow range. The up and down divider values are inputs. There is no back-pressure on either side. A `start` that arrives while the sequence runs is dropped. A write strobe is a one-cycle command that the register must take.

Top module: `pll_reseq`

## Requirements
- R1: A `start` pulse while idle captures the request fields and `cur_cfg`, and `busy` is high from the next cycle. The configuration word places N at the lowest NW bits, K directly above N, M above K, and P in the top PW bits.
- R2: When the requested P exceeds the captured P, the first configuration write changes only the P field. The next write follows no sooner than DIV_WAIT+1 cycles later.
- R3: When the requested M exceeds the captured M, a write that changes only M comes next (after any P raise). The next write follows no sooner than DIV_WAIT+1 cycles later.
- R4: A divider whose requested value is equal to or below the captured one is not written before the multiplier update, and no configuration writes occur beyond those listed in R2, R3, R5 and R7.
- R5: N and K are written together in one strobe. In that word, P and M are never below the captured values.
- R6: After the N/K write the sequencer waits SETTLE cycles, then watches `lock`. No further configuration write is issued until `lock` reads 1.
- R7: After lock, a lowered P is written, then a lowered M. The final register content equals the request.
- R8: Let the rate figure be (N+1)(K+1) compared against (M+1)·2^P. The setting is fast when (N+1)(K+1) > HI_RATIO·(M+1)·2^P. If the request is fast and the captured word is not, `bus_div_up` is written on the bus-divider strobe before any configuration write.
- R9: The setting is slow when (N+1)(K+1) < LO_RATIO·(M+1)·2^P. If the request is slow and the captured word is not, `bus_div_down` is written after the last configuration write.
- R10: A `start` while busy is ignored: neither its request fields nor later changes on the request inputs alter the running sequence.
- R11: `done` pulses for exactly one cycle at the end, with `busy` already low. No write strobe is high while `busy` is low.
- R12: If `lock` stays low for LOCK_TMO cycles of watching, the sequence ends with `err` high. No divider-lowering write or bus-divider lowering is issued. `err` holds until the next accepted `start` clears it.
- R13: After reset, `busy`, `done`, `err`, `cfg_wr` and `bus_wr` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, taken only while idle |
| req_n | input | NW | Requested N |
| req_k | input | KW | Requested K |
| req_m | input | MW | Requested post-divider M |
| req_p | input | PW | Requested pre-divider P |
| cur_cfg | input | NW+KW+MW+PW | Live configuration word |
| lock | input | 1 | Generator lock status |
| bus_div_up | input | BDW | Bus divider value for a fast target |
| bus_div_down | input | BDW | Bus divider value for a slow target |
| cfg_wr | output | 1 | Configuration write strobe |
| cfg_wdata | output | NW+KW+MW+PW | Configuration write word |
| bus_wr | output | 1 | Bus divider write strobe |
| bus_wdata | output | BDW | Bus divider write value |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last sequence ended on lock timeout |

## Verification
The main function is exercised with every pairing of current and requested words in a 5-bit configuration. Each divider is therefore seen rising, falling and staying put, in every combination with the other divider and with unchanged or changed multipliers. This separates a write issued for the wrong direction, in the wrong phase, or with stray fields. The same sweep covers all crossings into and out of the fast and slow rate ranges, so a misplaced or missing bus-divider write is exposed. A subset of runs injects a second request with scrambled fields mid-sequence, which shows whether the request is latched. Runs with a generator model that never relocks separate the timeout path from the normal finish.

// File: rtl/pll_seq_pkg.sv
`timescale 1ns/1ps
package pll_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_BUS_UP, ST_P_UP, ST_M_UP, ST_NK, ST_WAIT,
    ST_POLL, ST_P_DN, ST_M_DN, ST_BUS_DN, ST_DONE
  } seq_state_e;
endpackage

// File: rtl/pll_seq_rate.sv
`timescale 1ns/1ps
// Classifies a factor set as fast or slow against two fixed ratios.
module pll_seq_rate #(
  parameter int NW = 8,
  parameter int KW = 2,
  parameter int MW = 2,
  parameter int PW = 2,
  parameter int HI_RATIO = 64,
  parameter int LO_RATIO = 16,
  localparam int CW = NW + KW + MW + PW
) (
  input  logic [CW-1:0] cfg,
  output logic          fast,
  output logic          slow
);
  logic [31:0] num, den;

  always_comb begin
    num  = (32'(cfg[NW-1:0]) + 32'd1) * (32'(cfg[NW +: KW]) + 32'd1);
    den  = (32'(cfg[NW+KW +: MW]) + 32'd1) << cfg[NW+KW+MW +: PW];
    fast = num > (32'(HI_RATIO) * den);
    slow = num < (32'(LO_RATIO) * den);
  end
endmodule

// File: rtl/pll_seq_timer.sv
`timescale 1ns/1ps
// Loadable down counter shared by all waits of the sequence.
module pll_seq_timer #(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [TW-1:0] val,
  output logic          expired
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (ld)           cnt <= val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/pll_reseq.sv
`timescale 1ns/1ps
module pll_reseq
  import pll_seq_pkg::*;
#(
  parameter int NW       = 8,
  parameter int KW       = 2,
  parameter int MW       = 2,
  parameter int PW       = 2,
  parameter int BDW      = 3,
  parameter int DIV_WAIT = 2000,
  parameter int SETTLE   = 20,
  parameter int LOCK_TMO = 100000,
  parameter int HI_RATIO = 64,
  parameter int LO_RATIO = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [NW-1:0]             req_n,
  input  logic [KW-1:0]             req_k,
  input  logic [MW-1:0]             req_m,
  input  logic [PW-1:0]             req_p,
  input  logic [NW+KW+MW+PW-1:0]    cur_cfg,
  input  logic                      lock,
  input  logic [BDW-1:0]            bus_div_up,
  input  logic [BDW-1:0]            bus_div_down,
  output logic                      cfg_wr,
  output logic [NW+KW+MW+PW-1:0]    cfg_wdata,
  output logic                      bus_wr,
  output logic [BDW-1:0]            bus_wdata,
  output logic                      busy,
  output logic                      done,
  output logic                      err
);
  localparam int CW    = NW + KW + MW + PW;
  localparam int NKW   = NW + KW;
  localparam int M_LSB = NW + KW;
  localparam int P_LSB = NW + KW + MW;
  localparam int TMAX  = (LOCK_TMO > DIV_WAIT) ?
                         ((LOCK_TMO > SETTLE) ? LOCK_TMO : SETTLE) :
                         ((DIV_WAIT > SETTLE) ? DIV_WAIT : SETTLE);
  localparam int TW    = $clog2(TMAX + 1);

  seq_state_e       state, state_d, ret, ret_d;
  logic [CW-1:0]    work, work_d, tgt, req_word, wdat_d;
  logic [BDW-1:0]   up_val, dn_val, bdat_d;
  logic             p_inc, m_inc, p_dec, m_dec, bus_lo;
  logic             wr_d, bwr_d, done_d, err_d, take;
  logic             tmr_ld, tmr_exp;
  logic [TW-1:0]    tmr_val;
  logic             cur_fast, cur_slow, req_fast, req_slow;

  assign req_word = {req_p, req_m, req_k, req_n};
  assign busy     = (state != ST_IDLE);

  pll_seq_rate #(.NW(NW), .KW(KW), .MW(MW), .PW(PW),
                 .HI_RATIO(HI_RATIO), .LO_RATIO(LO_RATIO))
    u_rate_cur (.cfg(cur_cfg), .fast(cur_fast), .slow(cur_slow));

  pll_seq_rate #(.NW(NW), .KW(KW), .MW(MW), .PW(PW),
                 .HI_RATIO(HI_RATIO), .LO_RATIO(LO_RATIO))
    u_rate_req (.cfg(req_word), .fast(req_fast), .slow(req_slow));

  pll_seq_timer #(.TW(TW))
    u_timer (.clk(clk), .rst_n(rst_n), .ld(tmr_ld), .val(tmr_val), .expired(tmr_exp));

  // Next-state and write decisions; every strobe is registered below.
  always_comb begin
    state_d = state;
    ret_d   = ret;
    work_d  = work;
    wr_d    = 1'b0;
    wdat_d  = cfg_wdata;
    bwr_d   = 1'b0;
    bdat_d  = bus_wdata;
    done_d  = 1'b0;
    err_d   = err;
    take    = 1'b0;
    tmr_ld  = 1'b0;
    tmr_val = '0;
    unique case (state)
      ST_IDLE: if (start) begin
        take    = 1'b1;
        err_d   = 1'b0;
        work_d  = cur_cfg;
        state_d = (req_fast && !cur_fast) ? ST_BUS_UP : ST_P_UP;
      end
      ST_BUS_UP: begin
        bwr_d   = 1'b1;
        bdat_d  = up_val;
        state_d = ST_P_UP;
      end
      ST_P_UP: begin
        state_d = ST_M_UP;
        if (p_inc) begin
          work_d[P_LSB +: PW] = tgt[P_LSB +: PW];
          wr_d    = 1'b1;
          wdat_d  = work_d;
          tmr_ld  = 1'b1;
          tmr_val = TW'(DIV_WAIT - 1);
          ret_d   = ST_M_UP;
          state_d = ST_WAIT;
        end
      end
      ST_M_UP: begin
        state_d = ST_NK;
        if (m_inc) begin
          work_d[M_LSB +: MW] = tgt[M_LSB +: MW];
          wr_d    = 1'b1;
          wdat_d  = work_d;
          tmr_ld  = 1'b1;
          tmr_val = TW'(DIV_WAIT - 1);
          ret_d   = ST_NK;
          state_d = ST_WAIT;
        end
      end
      ST_NK: begin
        work_d[0 +: NKW] = tgt[0 +: NKW];
        wr_d    = 1'b1;
        wdat_d  = work_d;
        tmr_ld  = 1'b1;
        tmr_val = TW'(SETTLE - 1);
        ret_d   = ST_POLL;
        state_d = ST_WAIT;
      end
      ST_WAIT: if (tmr_exp) begin
        state_d = ret;
        if (ret == ST_POLL) begin
          tmr_ld  = 1'b1;
          tmr_val = TW'(LOCK_TMO - 1);
        end
      end
      ST_POLL: begin
        if (lock) state_d = ST_P_DN;
        else if (tmr_exp) begin
          err_d   = 1'b1;
          state_d = ST_DONE;
        end
      end
      ST_P_DN: begin
        state_d = ST_M_DN;
        if (p_dec) begin
          work_d[P_LSB +: PW] = tgt[P_LSB +: PW];
          wr_d   = 1'b1;
          wdat_d = work_d;
        end
      end
      ST_M_DN: begin
        state_d = ST_BUS_DN;
        if (m_dec) begin
          work_d[M_LSB +: MW] = tgt[M_LSB +: MW];
          wr_d   = 1'b1;
          wdat_d = work_d;
        end
      end
      ST_BUS_DN: begin
        state_d = ST_DONE;
        if (bus_lo) begin
          bwr_d  = 1'b1;
          bdat_d = dn_val;
        end
      end
      ST_DONE: begin
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      ret       <= ST_IDLE;
      work      <= '0;
      tgt       <= '0;
      p_inc     <= 1'b0;
      m_inc     <= 1'b0;
      p_dec     <= 1'b0;
      m_dec     <= 1'b0;
      bus_lo    <= 1'b0;
      up_val    <= '0;
      dn_val    <= '0;
      cfg_wr    <= 1'b0;
      cfg_wdata <= '0;
      bus_wr    <= 1'b0;
      bus_wdata <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      state     <= state_d;
      ret       <= ret_d;
      work      <= work_d;
      cfg_wr    <= wr_d;
      cfg_wdata <= wdat_d;
      bus_wr    <= bwr_d;
      bus_wdata <= bdat_d;
      done      <= done_d;
      err       <= err_d;
      if (take) begin
        tgt    <= req_word;
        p_inc  <= req_p > cur_cfg[P_LSB +: PW];
        p_dec  <= req_p < cur_cfg[P_LSB +: PW];
        m_inc  <= req_m > cur_cfg[M_LSB +: MW];
        m_dec  <= req_m < cur_cfg[M_LSB +: MW];
        bus_lo <= req_slow && !cur_slow;
        up_val <= bus_div_up;
        dn_val <= bus_div_down;
      end
    end
  end
endmodule

// File: rtl/pll_seq_chk.sv
`timescale 1ns/1ps
module pll_seq_chk #(
  parameter int NW = 8,
  parameter int KW = 2,
  parameter int MW = 2,
  parameter int PW = 2,
  localparam int CW = NW + KW + MW + PW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic          cfg_wr,
  input logic          bus_wr,
  input logic [CW-1:0] cfg_wdata,
  input logic [CW-1:0] cur_cfg,
  input logic          lock
);
  localparam int NKW   = NW + KW;
  localparam int M_LSB = NW + KW;
  localparam int P_LSB = NW + KW + MW;

  logic nk_change, div_drop, div_keep;
  assign nk_change = cfg_wdata[0 +: NKW] != cur_cfg[0 +: NKW];
  assign div_drop  = (cfg_wdata[P_LSB +: PW] < cur_cfg[P_LSB +: PW]) ||
                     (cfg_wdata[M_LSB +: MW] < cur_cfg[M_LSB +: MW]);
  assign div_keep  = (cfg_wdata[P_LSB +: PW] >= cur_cfg[P_LSB +: PW]) &&
                     (cfg_wdata[M_LSB +: MW] >= cur_cfg[M_LSB +: MW]);

  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);                                   // R1
  AST_NK_DIV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && nk_change) |-> div_keep);                          // R5
  AST_DROP_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && div_drop) |-> lock);                               // R7
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr && bus_wr));                                         // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!cfg_wr && !bus_wr));                              // R11
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);                                              // R11
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                              // R11
  AST_ERR_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |=> done);                                         // R12
endmodule

bind pll_reseq pll_seq_chk #(.NW(NW), .KW(KW), .MW(MW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .err(err), .cfg_wr(cfg_wr), .bus_wr(bus_wr), .cfg_wdata(cfg_wdata),
  .cur_cfg(cur_cfg), .lock(lock)
);

// File: tb/tb_pll_reseq.sv
`timescale 1ns/1ps
module tb_pll_reseq;
  localparam int NW = 2, KW = 1, MW = 1, PW = 1, BDW = 2;
  localparam int DIV_WAIT = 16, SETTLE = 4, LOCK_TMO = 64;
  localparam int HI_RATIO = 4, LO_RATIO = 1;
  localparam int CW = NW + KW + MW + PW;
  localparam int NKW = NW + KW;
  localparam int M_SH = NW + KW;
  localparam int P_SH = NW + KW + MW;
  localparam int LOCK_DLY = 10;
  localparam int UPV = 3, DNV = 1;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, lock_m;
  logic [NW-1:0] req_n = '0;
  logic [KW-1:0] req_k = '0;
  logic [MW-1:0] req_m = '0;
  logic [PW-1:0] req_p = '0;
  logic [CW-1:0] pll, mdl_val = '0, cfg_wdata;
  logic mdl_load = 1'b1, stuck = 1'b0;
  logic cfg_wr, bus_wr, busy, done, err;
  logic [BDW-1:0] bus_wdata;
  int lcnt;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  pll_reseq #(.NW(NW), .KW(KW), .MW(MW), .PW(PW), .BDW(BDW),
              .DIV_WAIT(DIV_WAIT), .SETTLE(SETTLE), .LOCK_TMO(LOCK_TMO),
              .HI_RATIO(HI_RATIO), .LO_RATIO(LO_RATIO)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .req_n(req_n), .req_k(req_k),
    .req_m(req_m), .req_p(req_p), .cur_cfg(pll), .lock(lock_m),
    .bus_div_up(BDW'(UPV)), .bus_div_down(BDW'(DNV)),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .busy(busy), .done(done), .err(err));

  // Generator model: register plus delayed relock after a multiplier change.
  always @(posedge clk) begin
    if (mdl_load) begin
      pll <= mdl_val; lock_m <= 1'b1; lcnt <= 0;
    end else if (cfg_wr) begin
      pll <= cfg_wdata;
      if (cfg_wdata[NKW-1:0] != pll[NKW-1:0]) begin
        lock_m <= 1'b0; lcnt <= LOCK_DLY;
      end
    end else if (lcnt > 0) begin
      lcnt <= lcnt - 1;
      if (lcnt == 1 && !stuck) lock_m <= 1'b1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit is_fast(input int w);
    int num = ((w & 3) + 1) * (((w >> 2) & 1) + 1);
    int den = (((w >> M_SH) & 1) + 1) << ((w >> P_SH) & 1);
    return num > HI_RATIO * den;
  endfunction

  function automatic bit is_slow(input int w);
    int num = ((w & 3) + 1) * (((w >> 2) & 1) + 1);
    int den = (((w >> M_SH) & 1) + 1) << ((w >> P_SH) & 1);
    return num < LO_RATIO * den;
  endfunction

  task automatic run(input int cur, input int req, input bit intr, input bit stk);
    int exp_w[5];
    int nexp = 0, inc_cnt, nk_idx, w, cyc, idx, last_t, nk_t;
    int cp = (cur >> P_SH) & 1, cm = (cur >> M_SH) & 1;
    int rp = (req >> P_SH) & 1, rm = (req >> M_SH) & 1;
    bit exp_up, exp_dn, up_seen = 0, dn_seen = 0, last_inc = 0, fin = 0;
    w = cur;
    if (rp > cp) begin w = (w & ~(1 << P_SH)) | (rp << P_SH); exp_w[nexp] = w; nexp++; end
    if (rm > cm) begin w = (w & ~(1 << M_SH)) | (rm << M_SH); exp_w[nexp] = w; nexp++; end
    inc_cnt = nexp;
    w = (w & ~((1 << NKW) - 1)) | (req & ((1 << NKW) - 1));
    nk_idx = nexp; exp_w[nexp] = w; nexp++;
    if (!stk) begin
      if (rp < cp) begin w = (w & ~(1 << P_SH)) | (rp << P_SH); exp_w[nexp] = w; nexp++; end
      if (rm < cm) begin w = (w & ~(1 << M_SH)) | (rm << M_SH); exp_w[nexp] = w; nexp++; end
    end
    exp_up = is_fast(req) && !is_fast(cur);
    exp_dn = !stk && is_slow(req) && !is_slow(cur);

    @(negedge clk); mdl_load = 1'b1; mdl_val = CW'(cur); stuck = stk;
    @(negedge clk); mdl_load = 1'b0;
    req_n = NW'(req); req_k = KW'(req >> NW); req_m = MW'(req >> M_SH); req_p = PW'(req >> P_SH);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R1 busy after start", busy, 1);
    chk(err == 1'b0, "R12 err cleared by start", err, 0);
    cyc = 1; idx = 0; last_t = -100; nk_t = -100;
    while (!fin && cyc < 600) begin
      if (cfg_wr) begin
        if (idx < nexp) begin
          if (idx < inc_cnt)
            chk(int'(cfg_wdata) == exp_w[idx], "R2 R3 R4 raise write", int'(cfg_wdata), exp_w[idx]);
          else if (idx == nk_idx)
            chk(int'(cfg_wdata) == exp_w[idx], "R5 multiplier write", int'(cfg_wdata), exp_w[idx]);
          else
            chk(int'(cfg_wdata) == exp_w[idx], "R7 lowering write", int'(cfg_wdata), exp_w[idx]);
        end else chk(1'b0, "R4 extra write", idx + 1, nexp);
        if (last_inc) chk(cyc - last_t > DIV_WAIT, "R2 R3 wait after raise", cyc - last_t, DIV_WAIT + 1);
        if (idx > nk_idx) begin
          chk(lock_m == 1'b1, "R6 write before lock", lock_m, 1);
          chk(cyc - nk_t > SETTLE, "R6 settle wait", cyc - nk_t, SETTLE + 1);
        end
        last_inc = (idx < inc_cnt);
        last_t = cyc;
        if (idx == nk_idx) nk_t = cyc;
        idx++;
      end
      if (bus_wr) begin
        if (idx == 0 && exp_up && !up_seen) begin
          chk(int'(bus_wdata) == UPV, "R8 bus raise value", int'(bus_wdata), UPV); up_seen = 1;
        end else if (idx == nexp && exp_dn && !dn_seen) begin
          chk(int'(bus_wdata) == DNV, "R9 bus lower value", int'(bus_wdata), DNV); dn_seen = 1;
        end else chk(1'b0, "R8 R9 misplaced bus write", idx, -1);
      end
      if (done) fin = 1;
      else begin
        @(negedge clk); cyc++;
        if (intr) begin
          if (cyc == 3) begin
            start = 1'b1; req_n = ~req_n; req_k = ~req_k; req_m = ~req_m; req_p = ~req_p;
          end else start = 1'b0;
        end
      end
    end
    chk(fin, "R11 sequence finished", cyc, 600);
    chk(idx == nexp, "R4 R7 write count", idx, nexp);
    chk(up_seen == exp_up, "R8 bus raise issued", up_seen, exp_up);
    chk(dn_seen == exp_dn, "R9 bus lower issued", dn_seen, exp_dn);
    chk(err == stk, "R12 error flag", err, stk);
    chk(busy == 1'b0, "R11 idle at done", busy, 0);
    if (intr) chk(int'(pll) == w, "R10 busy start ignored", int'(pll), w);
    else      chk(int'(pll) == w, "R7 final config", int'(pll), w);
    if (!stk) chk(w == req, "R7 final equals request", w, req);
    @(negedge clk);
    chk(done == 1'b0, "R11 single done pulse", done, 0);
    if (stk) begin
      repeat (3) @(negedge clk);
      chk(err == 1'b1, "R12 err held", err, 1);
    end
  endtask

  initial begin
    #1950000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R13 busy at reset", busy, 0);
    chk(done == 1'b0, "R13 done at reset", done, 0);
    chk(err == 1'b0, "R13 err at reset", err, 0);
    chk(cfg_wr == 1'b0 && bus_wr == 1'b0, "R13 strobes at reset", cfg_wr, 0);
    for (int c = 0; c < 32; c++)
      for (int r = 0; r < 32; r++)
        run(c, r, ((c * 32 + r) % 13) == 5, 1'b0);
    run(5'b00001, 5'b11011, 1'b0, 1'b1);
    run(5'b11000, 5'b00111, 1'b0, 1'b1);
    run(5'b11111, 5'b00000, 1'b0, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule